// File: doc/BRIEF.md
# Transaction Ordering Sequence Gate

This block keeps program order among transactions that share a group. Several processors each present a commit-check request. The request is a 32-bit word that carries a group identifier and a sequence number. For every group the block keeps the next sequence number it expects. A request whose sequence number equals that value is accepted, and the stored value advances. A request that is ahead of it is told to roll back and replay later. A request that is behind it, or that names a group the table does not hold, is answered with an error.

Each processor lane has its own request and response. A response appears on the clock edge after its request. Requests that arrive in the same cycle are judged in ascending lane order, so a lower-indexed lane's accepted commit is already visible to a higher-indexed lane in that cycle. A table clear returns every group to sequence zero. The data commit itself happens elsewhere; this block only decides whether it may go ahead.

Top module: `txn_seq_gate`

## Requirements
- R1: After reset, every response output is low and every group expects sequence number zero.
- R2: In a request word, bits 31:16 hold the group ID and bits 15:0 hold the sequence number.
- R3: A lane that presents a request (req_valid high) at a rising edge shows resp_valid high right after that edge. A lane with no request shows resp_valid low. A sequence number equal to the group's expected value is answered with resp_accept.
- R4: An accepted request advances its group's expected value by one, modulo 2^16. Requests in the following cycle see the advanced value.
- R5: A sequence number greater than the expected value is answered with resp_rollback, and the group's expected value is left unchanged.
- R6: A sequence number smaller than the expected value is answered with resp_error, and the group's expected value is left unchanged.
- R7: Accepting, rolling back or rejecting a request for one group never alters the expected value of any other group.
- R8: A group ID of NUM_GROUPS or more is answered with resp_error and changes no table entry.
- R9: Requests in the same cycle are judged in ascending lane index. A lane sees its group's expected value raised by every accept from a lower-indexed lane in that group in that cycle.
- R10: When tbl_clear is high at an edge, every group's expected value becomes zero. Requests in that same cycle are judged against zero, and their accepts still advance the cleared value.
- R11: While resp_valid is high, exactly one of resp_accept, resp_rollback and resp_error is high. While resp_valid is low, all three are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_clear | input | 1 | Returns every group's expected sequence number to zero |
| req_valid | input | NUM_PROCS | Per-lane commit-check request strobe |
| req_word | input | NUM_PROCS*32 | Per-lane request word; lane p occupies bits p*32 and up |
| resp_valid | output | NUM_PROCS | Per-lane response present, one cycle after the request |
| resp_accept | output | NUM_PROCS | Commit may proceed |
| resp_rollback | output | NUM_PROCS | Transaction is ahead of its turn and must replay |
| resp_error | output | NUM_PROCS | Stale sequence number or unknown group |

## Verification
The hardest case to reach from the ports is a cycle in which several lanes share a group and the outcome of each lane depends on the accepts of the lanes before it. This is harder still when a table clear lands in the same cycle. The bench reaches these cases in two ways. It issues directed bursts that present consecutive sequence numbers on all lanes in ascending and in descending order. It also runs a long arithmetic sweep: lane groups are drawn from a small table so that collisions are frequent, sequence offsets lie around the current expected value, and a clear is inserted periodically. The table's contents are never read directly. They are inferred from later accept, rollback and error answers.

// File: rtl/txn_order_pkg.sv
`timescale 1ns/1ps
package txn_order_pkg;
  localparam int WORD_W = 32;
  localparam int GID_W  = 16;
  localparam int SEQ_W  = WORD_W - GID_W;

  typedef logic [WORD_W-1:0] cmt_word_t;
  typedef logic [GID_W-1:0]  gid_t;
  typedef logic [SEQ_W-1:0]  seq_t;

  // Outcome of one lane in one cycle
  typedef enum logic [1:0] {
    V_IDLE   = 2'd0,
    V_ACCEPT = 2'd1,
    V_RETRY  = 2'd2,
    V_FAULT  = 2'd3
  } verdict_e;

  function automatic gid_t word_gid(cmt_word_t w);
    return w[WORD_W-1 -: GID_W];
  endfunction

  function automatic seq_t word_seq(cmt_word_t w);
    return w[SEQ_W-1:0];
  endfunction

  function automatic seq_t seq_advance(seq_t s);
    return s + seq_t'(1);
  endfunction

  // Ordering rule: equal -> go, ahead -> replay, behind or unknown group -> fault
  function automatic verdict_e judge(logic valid, logic in_range, seq_t expected, seq_t seq);
    if (!valid)          return V_IDLE;
    if (!in_range)       return V_FAULT;
    if (seq == expected) return V_ACCEPT;
    if (seq > expected)  return V_RETRY;
    return V_FAULT;
  endfunction
endpackage

// File: rtl/txn_seq_table.sv
`timescale 1ns/1ps
module txn_seq_table
  import txn_order_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_PROCS  = 4,
  localparam int IDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                clear,
  input  logic [NUM_PROCS-1:0]                wr_en,
  input  logic [NUM_PROCS-1:0][IDX_W-1:0]     wr_idx,
  input  seq_t [NUM_PROCS-1:0]                wr_val,
  output seq_t [NUM_GROUPS-1:0]               entries,
  output logic [NUM_GROUPS-1:0]               group_hit
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_entry
    seq_t cur;
    seq_t nxt;
    logic hit;

    // Later lanes overwrite earlier ones: they hold the furthest-advanced value
    always_comb begin
      hit = 1'b0;
      nxt = clear ? '0 : cur;
      for (int p = 0; p < NUM_PROCS; p++) begin
        if (wr_en[p] && (wr_idx[p] == IDX_W'(g))) begin
          hit = 1'b1;
          nxt = wr_val[p];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cur <= '0;
      else        cur <= nxt;
    end

    assign entries[g]   = cur;
    assign group_hit[g] = hit;
  end
endmodule

// File: rtl/txn_order_lane.sv
`timescale 1ns/1ps
module txn_order_lane
  import txn_order_pkg::*;
#(
  parameter int IDX        = 0,
  parameter int NUM_PROCS  = 4,
  parameter int NUM_GROUPS = 8,
  localparam int IDX_W  = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int BUMP_W = $clog2(NUM_PROCS + 1)
) (
  input  logic                      valid,
  input  seq_t                      seq_in,
  input  logic                      clear,
  input  seq_t [NUM_GROUPS-1:0]     entries,
  input  gid_t [NUM_PROCS-1:0]      all_gid,
  input  logic [NUM_PROCS-1:0]      acc_in,
  output logic [NUM_PROCS-1:0]      acc_out,
  output verdict_e                  verdict,
  output logic [IDX_W-1:0]          grp_idx,
  output seq_t                      next_val
);
  gid_t              my_gid;
  logic              in_range;
  seq_t              base;
  seq_t              expected;
  logic [BUMP_W-1:0] bump;

  assign my_gid   = all_gid[IDX];
  assign in_range = my_gid < gid_t'(NUM_GROUPS);
  assign grp_idx  = my_gid[IDX_W-1:0];
  assign base     = (clear || !in_range) ? '0 : entries[grp_idx];

  // Count accepts granted to lower lanes of the same group this cycle
  always_comb begin
    bump = '0;
    for (int j = 0; j < NUM_PROCS; j++) begin
      if (j < IDX && acc_in[j] && (all_gid[j] == my_gid))
        bump = bump + BUMP_W'(1);
    end
  end

  assign expected = base + seq_t'(bump);
  assign verdict  = judge(valid, in_range, expected, seq_in);
  assign next_val = seq_advance(seq_in);

  always_comb begin
    acc_out      = acc_in;
    acc_out[IDX] = (verdict == V_ACCEPT);
  end
endmodule

// File: rtl/txn_resp_stage.sv
`timescale 1ns/1ps
module txn_resp_stage
  import txn_order_pkg::*;
#(
  parameter int NUM_PROCS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  verdict_e             verdict [NUM_PROCS],
  output logic [NUM_PROCS-1:0] resp_valid,
  output logic [NUM_PROCS-1:0] resp_accept,
  output logic [NUM_PROCS-1:0] resp_rollback,
  output logic [NUM_PROCS-1:0] resp_error
);
  verdict_e held [NUM_PROCS];

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_PROCS; p++) begin
      if (!rst_n) held[p] <= V_IDLE;
      else        held[p] <= verdict[p];
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PROCS; p++) begin
      resp_valid[p]    = (held[p] != V_IDLE);
      resp_accept[p]   = (held[p] == V_ACCEPT);
      resp_rollback[p] = (held[p] == V_RETRY);
      resp_error[p]    = (held[p] == V_FAULT);
    end
  end
endmodule

// File: rtl/txn_seq_gate.sv
`timescale 1ns/1ps
module txn_seq_gate
  import txn_order_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_GROUPS = 8,
  localparam int IDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        tbl_clear,
  input  logic [NUM_PROCS-1:0]        req_valid,
  input  logic [NUM_PROCS*WORD_W-1:0] req_word,
  output logic [NUM_PROCS-1:0]        resp_valid,
  output logic [NUM_PROCS-1:0]        resp_accept,
  output logic [NUM_PROCS-1:0]        resp_rollback,
  output logic [NUM_PROCS-1:0]        resp_error
);
  // Named internal events, visible to the bound checker
  gid_t [NUM_PROCS-1:0]            lane_gid;
  seq_t [NUM_PROCS-1:0]            lane_seq;
  verdict_e                        lane_verdict [NUM_PROCS];
  logic [NUM_PROCS-1:0][IDX_W-1:0] lane_idx;
  seq_t [NUM_PROCS-1:0]            lane_next;
  logic [NUM_PROCS-1:0]            lane_accept;
  seq_t [NUM_GROUPS-1:0]           table_entries;
  logic [NUM_GROUPS-1:0]           group_hit;

  for (genvar i = 0; i < NUM_PROCS; i++) begin : g_lane
    logic [NUM_PROCS-1:0] acc_prior;
    logic [NUM_PROCS-1:0] acc_seen;

    assign lane_gid[i] = word_gid(req_word[i*WORD_W +: WORD_W]);
    assign lane_seq[i] = word_seq(req_word[i*WORD_W +: WORD_W]);

    // Accept history flows lane to lane in index order
    if (i == 0) begin : g_head
      assign acc_prior = '0;
    end else begin : g_link
      assign acc_prior = g_lane[i-1].acc_seen;
    end

    txn_order_lane #(
      .IDX        (i),
      .NUM_PROCS  (NUM_PROCS),
      .NUM_GROUPS (NUM_GROUPS)
    ) u_lane (
      .valid    (req_valid[i]),
      .seq_in   (lane_seq[i]),
      .clear    (tbl_clear),
      .entries  (table_entries),
      .all_gid  (lane_gid),
      .acc_in   (acc_prior),
      .acc_out  (acc_seen),
      .verdict  (lane_verdict[i]),
      .grp_idx  (lane_idx[i]),
      .next_val (lane_next[i])
    );
  end

  assign lane_accept = g_lane[NUM_PROCS-1].acc_seen;

  txn_seq_table #(
    .NUM_GROUPS (NUM_GROUPS),
    .NUM_PROCS  (NUM_PROCS)
  ) u_table (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (tbl_clear),
    .wr_en     (lane_accept),
    .wr_idx    (lane_idx),
    .wr_val    (lane_next),
    .entries   (table_entries),
    .group_hit (group_hit)
  );

  txn_resp_stage #(
    .NUM_PROCS (NUM_PROCS)
  ) u_resp (
    .clk           (clk),
    .rst_n         (rst_n),
    .verdict       (lane_verdict),
    .resp_valid    (resp_valid),
    .resp_accept   (resp_accept),
    .resp_rollback (resp_rollback),
    .resp_error    (resp_error)
  );
endmodule

// File: rtl/txn_seq_gate_sva.sv
`timescale 1ns/1ps
module txn_seq_gate_sva
  import txn_order_pkg::*;
#(
  parameter int NUM_PROCS  = 4,
  parameter int NUM_GROUPS = 8,
  localparam int IDX_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        tbl_clear,
  input logic [NUM_PROCS-1:0]        req_valid,
  input logic [NUM_PROCS*WORD_W-1:0] req_word,
  input logic [NUM_PROCS-1:0]        resp_valid,
  input logic [NUM_PROCS-1:0]        resp_accept,
  input logic [NUM_PROCS-1:0]        resp_rollback,
  input logic [NUM_PROCS-1:0]        resp_error,
  input seq_t [NUM_GROUPS-1:0]       table_entries,
  input logic [NUM_GROUPS-1:0]       group_hit
);
  for (genvar p = 0; p < NUM_PROCS; p++) begin : g_p
    gid_t pg;
    seq_t ps;
    logic lower_idle;
    assign pg = req_word[p*WORD_W+SEQ_W +: GID_W];
    assign ps = req_word[p*WORD_W +: SEQ_W];
    assign lower_idle = (p == 0) ? 1'b1 : ((req_valid & NUM_PROCS'((1 << p) - 1)) == '0);

    assert_one_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid[p] |-> $countones({resp_accept[p], resp_rollback[p], resp_error[p]}) == 1);
    assert_quiet_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !resp_valid[p] |-> !(resp_accept[p] || resp_rollback[p] || resp_error[p]));
    assert_answer_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[p] |=> resp_valid[p]);
    assert_no_phantom_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid[p] |=> !resp_valid[p]);
    assert_unknown_group_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && pg >= gid_t'(NUM_GROUPS)) |=> resp_error[p]);
    assert_stale_rejected_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[p] && lower_idle && !tbl_clear && pg < gid_t'(NUM_GROUPS)
       && ps < table_entries[pg[IDX_W-1:0]]) |=> resp_error[p]);
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_g
    // R5/R6/R7: a group no lane accepted keeps its value
    assert_hold_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tbl_clear && !group_hit[g]) |=> $stable(table_entries[g]));
    assert_advance_on_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tbl_clear && group_hit[g]) |=> (table_entries[g] != $past(table_entries[g])));
    assert_clear_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl_clear && !group_hit[g]) |=> (table_entries[g] == '0));
  end
endmodule

bind txn_seq_gate txn_seq_gate_sva #(
  .NUM_PROCS  (NUM_PROCS),
  .NUM_GROUPS (NUM_GROUPS)
) u_sva (
  .clk           (clk),
  .rst_n         (rst_n),
  .tbl_clear     (tbl_clear),
  .req_valid     (req_valid),
  .req_word      (req_word),
  .resp_valid    (resp_valid),
  .resp_accept   (resp_accept),
  .resp_rollback (resp_rollback),
  .resp_error    (resp_error),
  .table_entries (table_entries),
  .group_hit     (group_hit)
);

// File: tb/test_txn_seq_gate.sv
`timescale 1ns/1ps
module test_txn_seq_gate;
  localparam int P = 4;
  localparam int G = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tbl_clear = 1'b0;
  logic [P-1:0]   req_valid = '0;
  logic [P*32-1:0] req_word = '0;
  logic [P-1:0]   resp_valid, resp_accept, resp_rollback, resp_error;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  int unsigned model [G];
  logic [P-1:0] st_valid;
  logic [31:0]  st_word [P];
  logic         st_clear;
  string        st_tag [P];

  always #5 clk = ~clk;

  txn_seq_gate #(.NUM_PROCS(P), .NUM_GROUPS(G)) i_txn_seq_gate (
    .clk(clk), .rst_n(rst_n), .tbl_clear(tbl_clear),
    .req_valid(req_valid), .req_word(req_word),
    .resp_valid(resp_valid), .resp_accept(resp_accept),
    .resp_rollback(resp_rollback), .resp_error(resp_error)
  );

  task automatic chk(bit ok, string tag, int lane, logic [3:0] got, logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s lane %0d: got {v,acc,rb,err}=%b expected %b", tag, lane, got, exp);
    end
  endtask

  task automatic stage_reset();
    st_valid = '0;
    st_clear = 1'b0;
    for (int p = 0; p < P; p++) begin
      st_word[p] = '0;
      st_tag[p] = "";
    end
  endtask

  task automatic put(int p, int g, int s, string tag);
    st_valid[p] = 1'b1;
    st_word[p]  = {16'(g), 16'(s)};
    st_tag[p]   = tag;
  endtask

  task automatic check_idle(string tag);
    for (int p = 0; p < P; p++)
      chk({resp_valid[p], resp_accept[p], resp_rollback[p], resp_error[p]} == 4'b0000, tag, p,
          {resp_valid[p], resp_accept[p], resp_rollback[p], resp_error[p]}, 4'b0000);
  endtask

  // Predicts from the requirements, drives one cycle, checks each lane's answer
  task automatic fire();
    logic [3:0] expv [P];
    string      tg [P];
    if (st_clear) for (int g = 0; g < G; g++) model[g] = 0;
    for (int p = 0; p < P; p++) begin
      if (!st_valid[p]) begin
        expv[p] = 4'b0000; tg[p] = "R11";
      end else begin
        int g;
        int unsigned s;
        g = int'(st_word[p][31:16]);
        s = st_word[p][15:0];
        if (g >= G) begin
          expv[p] = 4'b1001; tg[p] = "R8";
        end else if (s == model[g]) begin
          expv[p] = 4'b1100; tg[p] = "R3";
          model[g] = (model[g] + 1) & 32'hFFFF;
        end else if (s > model[g]) begin
          expv[p] = 4'b1010; tg[p] = "R5";
        end else begin
          expv[p] = 4'b1001; tg[p] = "R6";
        end
        if (st_tag[p] != "") tg[p] = st_tag[p];
      end
    end
    tbl_clear = st_clear;
    req_valid = st_valid;
    for (int p = 0; p < P; p++) req_word[p*32 +: 32] = st_word[p];
    @(posedge clk);
    @(negedge clk);
    tbl_clear = 1'b0;
    req_valid = '0;
    for (int p = 0; p < P; p++)
      chk({resp_valid[p], resp_accept[p], resp_rollback[p], resp_error[p]} == expv[p], tg[p], p,
          {resp_valid[p], resp_accept[p], resp_rollback[p], resp_error[p]}, expv[p]);
    stage_reset();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete (got hang, expected completion)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pat [8] = '{3, 0, 1, 0, 2, 5, 2, 3};
    stage_reset();
    for (int g = 0; g < G; g++) model[g] = 0;

    // R1: outputs quiet in and after reset, every group at zero
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1");
    for (int p = 0; p < P; p++) put(p, p, 0, "R1");
    fire();

    // R2: field placement, including a sequence value that would be a bad group if swapped
    st_valid[0] = 1'b1; st_word[0] = 32'h0002_0001; st_tag[0] = "R2";
    st_valid[1] = 1'b1; st_word[1] = 32'h0000_0003; st_tag[1] = "R2";
    st_valid[2] = 1'b1; st_word[2] = 32'h0001_0004; st_tag[2] = "R2";
    fire();
    st_valid[3] = 1'b1; st_word[3] = 32'h0004_0000; st_tag[3] = "R2";
    fire();

    // R3/R5/R6/R8: single-lane sweep of every group (plus two unknown ones) over a seq pattern
    for (int g = 0; g < G + 2; g++)
      for (int k = 0; k < 8; k++) begin
        put(g % P, g, (g < G) ? int'(model[g]) + pat[k] - 1 : pat[k], "");
        if (g < G && model[g] == 0 && pat[k] == 0) st_word[g % P][15:0] = 16'hFFFF;
        fire();
      end

    // R4: accept, replay of the same number is stale, next number accepted
    begin
      int e;
      e = int'(model[1]);
      put(2, 1, e, "R4");     fire();
      put(2, 1, e, "R4");     fire();
      put(2, 1, e + 1, "R4"); fire();
    end

    // R7: activity on groups 0 and 1 leaves groups 2 and 3 untouched
    begin
      int e2, e3;
      e2 = int'(model[2]); e3 = int'(model[3]);
      put(0, 0, int'(model[0]), "R7"); put(1, 1, int'(model[1]) + 3, "R7");
      fire();
      put(0, 0, int'(model[0]) + 2, "R7"); put(1, 1, 0, "R7");
      fire();
      put(2, 2, e2, "R7"); put(3, 3, e3, "R7");
      fire();
    end

    // R9: same group on all lanes, ascending then descending numbers
    begin
      int e;
      e = int'(model[2]);
      for (int p = 0; p < P; p++) put(p, 2, e + p, "R9");
      fire();
      e = int'(model[2]);
      for (int p = 0; p < P; p++) put(p, 2, e + P - 1 - p, "R9");
      fire();
      e = int'(model[3]);
      put(0, 3, e, "R9"); put(1, 0, int'(model[0]), "R9"); put(2, 3, e + 1, "R9"); put(3, 3, e, "R9");
      fire();
    end

    // R10: clear alone, then clear together with requests
    st_clear = 1'b1; fire();
    for (int p = 0; p < P; p++) put(p, p, 0, "R10");
    fire();
    st_clear = 1'b1; put(0, 1, 0, "R10"); put(1, 1, 1, "R10"); put(2, 1, 5, "R10"); put(3, 0, 0, "R10");
    fire();
    put(0, 1, 2, "R10"); put(1, 0, 1, "R10");
    fire();

    // R9/R10/R11: arithmetic sweep with dense group collisions and periodic clears
    for (int k = 0; k < 600; k++) begin
      for (int p = 0; p < P; p++) begin
        int g, off;
        if (((k + p) % 5) != 0) begin
          g   = ((k * 5 + p * 3) >> 1) % (G + 1);
          off = (((k * 13 + p * 7) >> 1) % 4) - 1;
          put(p, g, (g < G) ? int'(model[g]) + off : off + 1, "R9");
        end
      end
      if ((k % 37) == 36) st_clear = 1'b1;
      fire();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule